// File: doc/BRIEF.md
# Interrupt Flag and Mask Register Pair

This block holds six interrupt request flags and six matching enable flags behind a byte-wide register port. Hardware event sources pulse request flags high; the host reads both registers and changes them with a mask write. The most significant bit of each write is not stored. Instead it chooses whether the ones in the low six bits set or clear the matching flags. Zeros leave their flags alone, so the host never needs a read-modify-write sequence.

Each request flag is gated by its enable flag, and the gated flags are ORed into one internal request. A small pin configuration register sets the polarity of the interrupt pin and chooses between push-pull and open-drain drive. An idle qualifier decides whether the end of a command raises the idle request.

Top module: `irq_regs_top`

## Requirements
- R1: After reset the request and enable registers read 00h, the pin configuration register reads 02h (inverted polarity, open-drain), the internal request is low, and the pin is released (`irq_oe_o`=0, `irq_o`=0).
- R2: A request register write (address 0) with bit 7 = 1 sets every request flag whose bit in 5..0 is 1 and leaves the others unchanged; writing 81h sets only bit 0.
- R3: A request register write with bit 7 = 0 clears every request flag whose bit in 5..0 is 1 and leaves the others unchanged; writing 3Fh clears all six.
- R4: Bits 7 and 6 of the request and enable registers always read 0, whatever was written to them.
- R5: The enable register (address 1) has the same layout and the same set/clear write rule, and it changes only on its own writes.
- R6: A high pulse on `src_set_i[k]` sets request bit k (bit 5 timer, 4 transmit, 3 receive, 2 idle, 1 high alert, 0 low alert); with no write and no event the request register holds.
- R7: A hardware set pulse in the same cycle as a host clear of that bit wins, and the bit stays 1.
- R8: The idle request (bit 2) is set when a running command ends into idle (`cmd_idle_i`) unless the host started the idle command in that cycle (`host_idle_i`), and it is always set when an unknown command is started (`cmd_bad_i`).
- R9: `irq_int_o` is the OR over bits 5..0 of the request flags ANDed with their enable flags.
- R10: At address 2, bit 1 inverts the pin level and bit 0 selects push-pull (1) or open-drain (0). Bits 7..2 read 0. In push-pull mode `irq_oe_o`=1 and `irq_o` carries the level. In open-drain mode `irq_o`=0 and `irq_oe_o` is 1 only when the level is low.
- R11: Address 3 reads 00h, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select for read and write |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data of the selected register |
| src_set_i | input | 6 | Hardware set pulses for the request flags |
| cmd_idle_i | input | 1 | A running command ended into idle |
| cmd_bad_i | input | 1 | An unknown command was started |
| host_idle_i | input | 1 | The host started the idle command |
| irq_int_o | output | 1 | Combined internal request |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe_o | output | 1 | Interrupt pin output enable |

## Verification
The bench hits a set pulse in the same cycle as a mask clear of the same bit. A design that lets the host win would lose the event and read the bit back as 0. Mask writes with zeros in some positions show whether a design overwrites the whole register instead of touching only the selected bits. Writes with bit 6 set show whether it ever reads back 1. The idle case, where the host's own idle start comes together with a command termination, must leave bit 2 clear. The bench also steps through all four pin configurations and checks `irq_o` and `irq_oe_o`, which catches a swapped polarity or swapped drive style.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned FLAG_N    = 6;
  localparam int unsigned PIN_PP    = 0;
  localparam int unsigned PIN_INV   = 1;
  localparam logic [1:0]  PIN_RST   = 2'b10;
  localparam int unsigned IDLE_BIT  = 2;

  typedef enum logic [1:0] {
    SEL_REQ  = 2'd0,
    SEL_EN   = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FLAGS  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [FLAGS-1:0]  hw_set_i,
  output logic [FLAGS-1:0]  flags_o
);
  localparam int unsigned MODE_IDX = DATA_W - 1;

  logic set_mode;
  assign set_mode = wr_data_i[MODE_IDX];

  for (genvar b = 0; b < FLAGS; b++) begin : g_bit
    logic hit, nxt, q;
    assign hit = wr_i & wr_data_i[b];
    // hardware set is ORed last so it beats a host clear
    always_comb begin
      nxt = q;
      if (hit) nxt = set_mode;
      nxt = nxt | hw_set_i[b];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= nxt;
    end
    assign flags_o[b] = q;
  end
endmodule

// File: rtl/irq_idle_qual.sv
module irq_idle_qual (
  input  logic cmd_idle_i,
  input  logic cmd_bad_i,
  input  logic host_idle_i,
  output logic idle_set_o
);
  assign idle_set_o = (cmd_idle_i & ~host_idle_i) | cmd_bad_i;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv
  import irq_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wr_cfg_i,
  input  logic       irq_int_i,
  output logic [1:0] cfg_o,
  output logic       irq_o,
  output logic       irq_oe_o
);
  logic [1:0] cfg_q;
  logic       level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= PIN_RST;
    else if (wr_i) cfg_q <= wr_cfg_i;
  end

  assign level = irq_int_i ^ cfg_q[PIN_INV];

  always_comb begin
    if (cfg_q[PIN_PP]) begin
      irq_o    = level;
      irq_oe_o = 1'b1;
    end else begin
      irq_o    = 1'b0;
      irq_oe_o = ~level;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/irq_regs_top.sv
module irq_regs_top
  import irq_regs_pkg::*;
#(
  parameter int unsigned DATA_W    = REG_W,
  parameter int unsigned NUM_FLAGS = FLAG_N
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           addr_i,
  input  logic                 wr_en_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic [NUM_FLAGS-1:0] src_set_i,
  input  logic                 cmd_idle_i,
  input  logic                 cmd_bad_i,
  input  logic                 host_idle_i,
  output logic                 irq_int_o,
  output logic                 irq_o,
  output logic                 irq_oe_o
);
  reg_sel_e sel;
  logic wr_req, wr_en_reg, wr_pin, idle_set;
  logic [NUM_FLAGS-1:0] req_q, en_q, req_hw_set;
  logic [1:0] pin_cfg;

  assign sel       = reg_sel_e'(addr_i);
  assign wr_req    = wr_en_i & (sel == SEL_REQ);
  assign wr_en_reg = wr_en_i & (sel == SEL_EN);
  assign wr_pin    = wr_en_i & (sel == SEL_PIN);

  irq_idle_qual u_idle (
    .cmd_idle_i (cmd_idle_i),
    .cmd_bad_i  (cmd_bad_i),
    .host_idle_i(host_idle_i),
    .idle_set_o (idle_set)
  );

  always_comb begin
    req_hw_set = src_set_i;
    req_hw_set[IDLE_BIT] = src_set_i[IDLE_BIT] | idle_set;
  end

  irq_mask_reg #(.DATA_W(DATA_W), .FLAGS(NUM_FLAGS)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_req),
    .wr_data_i(wr_data_i),
    .hw_set_i (req_hw_set),
    .flags_o  (req_q)
  );

  irq_mask_reg #(.DATA_W(DATA_W), .FLAGS(NUM_FLAGS)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_reg),
    .wr_data_i(wr_data_i),
    .hw_set_i ('0),
    .flags_o  (en_q)
  );

  assign irq_int_o = |(req_q & en_q);

  irq_pin_drv u_pin (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_pin),
    .wr_cfg_i (wr_data_i[1:0]),
    .irq_int_i(irq_int_o),
    .cfg_o    (pin_cfg),
    .irq_o    (irq_o),
    .irq_oe_o (irq_oe_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (sel)
      SEL_REQ:  rd_data_o[NUM_FLAGS-1:0] = req_q;
      SEL_EN:   rd_data_o[NUM_FLAGS-1:0] = en_q;
      SEL_PIN:  rd_data_o[1:0]           = pin_cfg;
      default:  rd_data_o                = '0;
    endcase
  end
endmodule

// File: rtl/irq_regs_chk.sv
module irq_regs_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_FLAGS = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [1:0]           addr_i,
  input logic                 wr_en_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic [DATA_W-1:0]    rd_data_o,
  input logic [NUM_FLAGS-1:0] src_set_i,
  input logic                 cmd_idle_i,
  input logic                 cmd_bad_i,
  input logic                 irq_int_o,
  input logic [NUM_FLAGS-1:0] req_q,
  input logic [NUM_FLAGS-1:0] en_q
);
  logic req_wr, en_wr, no_evt;
  assign req_wr = wr_en_i && addr_i == 2'd0;
  assign en_wr  = wr_en_i && addr_i == 2'd1;
  assign no_evt = (src_set_i == '0) && !cmd_idle_i && !cmd_bad_i;

  p_set_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_wr && wr_data_i[DATA_W-1] |=>
      (req_q & $past(wr_data_i[NUM_FLAGS-1:0])) == $past(wr_data_i[NUM_FLAGS-1:0]));

  p_clear_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_wr && !wr_data_i[DATA_W-1] && no_evt |=>
      (req_q & $past(wr_data_i[NUM_FLAGS-1:0])) == '0);

  p_top_bits_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:DATA_W-2] == 2'b00);

  p_en_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_wr |=> $stable(en_q));

  p_req_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_wr && no_evt |=> $stable(req_q));

  p_hw_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_set_i != '0 |=> (req_q & $past(src_set_i)) == $past(src_set_i));

  p_combine_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_int_o == |(req_q & en_q));
endmodule

bind irq_regs_top irq_regs_chk #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .src_set_i (src_set_i),
  .cmd_idle_i(cmd_idle_i),
  .cmd_bad_i (cmd_bad_i),
  .irq_int_o (irq_int_o),
  .req_q     (req_q),
  .en_q      (en_q)
);

// File: tb/irq_regs_top_bench.sv
module irq_regs_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [5:0] src_set = 6'h00;
  logic       cmd_idle = 1'b0, cmd_bad = 1'b0, host_idle = 1'b0;
  logic       irq_int, irq_pin, irq_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit         is_pin;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #10 clk = ~clk;

  irq_regs_top u_irq_regs_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .addr_i     (addr),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .src_set_i  (src_set),
    .cmd_idle_i (cmd_idle),
    .cmd_bad_i  (cmd_bad),
    .host_idle_i(host_idle),
    .irq_int_o  (irq_int),
    .irq_o      (irq_pin),
    .irq_oe_o   (irq_oe)
  );

  // monitor: compares mid low phase, after the driver has set the read address
  always @(negedge clk) begin
    #5;
    while (exp_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = exp_q.pop_front();
      act = it.is_pin ? {5'd0, irq_int, irq_pin, irq_oe} : rd_data;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [5:0] s = 6'h00);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; src_set = s;
    @(negedge clk);
    wr_en = 1'b0; src_set = 6'h00;
  endtask

  task automatic pulse(input logic [5:0] s, input logic ci, input logic cb, input logic hi);
    @(negedge clk);
    src_set = s; cmd_idle = ci; cmd_bad = cb; host_idle = hi;
    @(negedge clk);
    src_set = 6'h00; cmd_idle = 1'b0; cmd_bad = 1'b0; host_idle = 1'b0;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_pin = 1'b0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // expected {irq_int, irq_o, irq_oe}
  task automatic exp_pin(input logic [2:0] e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_pin = 1'b1; it.exp = {5'd0, e}; it.tag = tag;
    exp_q.push_back(it);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_rd(2'd0, 8'h00, "R1 req reset");
    exp_rd(2'd1, 8'h00, "R1 en reset");
    exp_rd(2'd2, 8'h02, "R1 pin cfg reset");
    exp_pin(3'b000, "R1 pin released");

    wr(2'd0, 8'h81);
    exp_rd(2'd0, 8'h01, "R2 81h sets low alert only");
    wr(2'd0, 8'h94);
    exp_rd(2'd0, 8'h15, "R2 mask set keeps others");
    wr(2'd0, 8'h44);
    exp_rd(2'd0, 8'h11, "R3 R4 clear bit2, bit6 ignored");
    wr(2'd0, 8'h3F);
    exp_rd(2'd0, 8'h00, "R3 3Fh clears all");

    wr(2'd1, 8'hA1);
    exp_rd(2'd1, 8'h21, "R5 enable set");
    wr(2'd1, 8'h01);
    exp_rd(2'd1, 8'h20, "R5 enable clear");
    exp_rd(2'd0, 8'h00, "R5 request untouched");

    pulse(6'h08, 1'b0, 1'b0, 1'b0);
    exp_rd(2'd0, 8'h08, "R6 receive event");
    exp_pin(3'b000, "R9 masked source");
    pulse(6'h20, 1'b0, 1'b0, 1'b0);
    exp_rd(2'd0, 8'h28, "R6 timer event");
    exp_pin(3'b101, "R9 R10 inv open-drain pulls low");

    wr(2'd2, 8'h01);
    exp_rd(2'd2, 8'h01, "R10 cfg push-pull");
    exp_pin(3'b111, "R10 push-pull true polarity");
    wr(2'd2, 8'hFF);
    exp_rd(2'd2, 8'h03, "R10 cfg upper bits zero");
    exp_pin(3'b101, "R10 push-pull inverted");

    wr(2'd0, 8'h28, 6'h20);
    exp_rd(2'd0, 8'h20, "R7 set beats clear");
    wr(2'd0, 8'h3F);
    exp_rd(2'd0, 8'h00, "R3 clear all again");
    exp_pin(3'b011, "R9 R10 idle level inverted high");

    pulse(6'h00, 1'b1, 1'b0, 1'b1);
    exp_rd(2'd0, 8'h00, "R8 host idle start no flag");
    pulse(6'h00, 1'b1, 1'b0, 1'b0);
    exp_rd(2'd0, 8'h04, "R8 command end sets idle");
    wr(2'd0, 8'h04);
    pulse(6'h00, 1'b0, 1'b1, 1'b1);
    exp_rd(2'd0, 8'h04, "R8 unknown command sets idle");

    exp_rd(2'd3, 8'h00, "R11 unused reads zero");
    wr(2'd3, 8'hFF);
    exp_rd(2'd0, 8'h04, "R11 req unchanged");
    exp_rd(2'd1, 8'h20, "R11 en unchanged");
    exp_rd(2'd2, 8'h03, "R11 cfg unchanged");

    wr(2'd1, 8'hFF);
    exp_rd(2'd1, 8'h3F, "R4 enable bits 7..6 read zero");
    exp_pin(3'b101, "R9 enabled idle raises request");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule